// File: doc/BRIEF.md
# DRAM Automatic Access Sequencer

This block is the front end of a dynamic RAM controller. It holds a row address, a column address and a bank number in registers. From them it drives a 9-bit multiplexed memory address bus, four active-low row strobes (one per bank) and one active-low column strobe. The write enable is not generated here. It passes straight from the system to the memory.

A 3-bit mode input picks who times the access. In the two external modes the system drives the row strobe, the column strobe and the row/column address select directly. The block only registers these inputs and decodes the bank. In the two automatic modes a single falling edge on the active-low access strobe starts the whole access:
- the selected bank's row strobe goes low;
- a row hold wait follows (short in the fast mode, long in the slow mode);
- the address bus changes from row to column;
- a column setup wait follows;
- the column strobe goes low.

Raising the access strobe ends the access and starts a short precharge window. A separate refresh arbiter can take over the address bus through a grant input. While it holds the grant, an access asserts all four row strobes and never the column strobe. All waits are counted in clock cycles and are set by parameters.

Top module: `dram_access_seq`

## Requirements
- R1: During and right after reset, all four row strobes and the column strobe are high (inactive), and the address bus reads 0.
- R2: A clock edge with `addrLoad` high captures `rowIn`, `colIn` and `bankIn`. With `addrLoad` low these registers keep their value. While no access is running, the address bus shows the captured row.
- R3: In an automatic mode, a clock edge that finds `accessN` low, after it was sampled high on the edge before, drives low only the row strobe whose index equals the captured bank (bank 0 drives `rasN[0]`). The address bus shows the row from that edge on.
- R4: In mode 3'b011 (automatic, fast), the address bus changes to the column exactly ROW_HOLD_FAST (default 2) cycles after the row strobe falls. The column strobe falls COL_SETUP (default 1) cycles after that.
- R5: In mode 3'b010 (automatic, slow), the column appears ROW_HOLD_SLOW (default 3) cycles after the row strobe falls. The column strobe falls COL_SETUP cycles after that.
- R6: In an automatic access, at any phase, the first edge that samples `accessN` high releases the row and column strobes and returns the address bus to the row.
- R7: After an automatic access ends there are PRECHARGE (default 1) precharge cycles. A falling `accessN` sampled during these cycles starts nothing, and it does not start an access later either.
- R8: In mode 3'b000 (external, one bank), one edge after they are sampled: the decoded row strobe equals `accessN`, `casN` equals `extCasN`, and the address bus shows the column when `extColSel` is 1 and the row otherwise.
- R9: In mode 3'b001 (external, all banks), `accessN` low drives all four row strobes low, one edge after it is sampled.
- R10: While `refreshGrant` is high, the address bus shows `refreshAddr`. In this state a started access (automatic or external) drives all four row strobes low and keeps the column strobe high.
- R11: Mode codes 3'b100 to 3'b111 start no access. In these modes (3'b111 is kept for loading the refresh end-of-count), `accessN` and `extCasN` have no effect on the strobes.
- R12: `weN` equals `weInN` at all times, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating mode code |
| addrLoad | input | 1 | Captures row, column and bank on the clock edge |
| rowIn | input | 9 | Row address |
| colIn | input | 9 | Column address |
| bankIn | input | 2 | Bank select |
| accessN | input | 1 | Active-low access strobe; in external modes, the row strobe |
| extCasN | input | 1 | Column strobe in external modes, active low |
| extColSel | input | 1 | Row/column address select in external modes (1 = column) |
| refreshGrant | input | 1 | Refresh arbiter owns the address bus |
| refreshAddr | input | 9 | Refresh row address from the arbiter |
| weInN | input | 1 | System write enable, active low |
| memAddr | output | 9 | Multiplexed memory address |
| rasN | output | 4 | Row strobes, one per bank, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Buffered write enable |

## Verification
The automatic sequence is run in both the fast and the slow mode, each with a different bank and different row and column patterns. This shows whether the row hold length really follows the mode, and whether the bank decode or the address mux mixes up fields. Two shortened accesses are also run: one released during the row hold, and one re-strobed inside the precharge window. These tell a correct release and ignore from a sequencer that carries on or restarts. The external modes are toggled one control at a time, so that each of the three controls shows up on its own output. Refresh grant and the reserved mode codes are driven with the same strobes, so any leak of an access or a column strobe would show.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    M_EXT_BANK  = 3'b000,
    M_EXT_ALL   = 3'b001,
    M_AUTO_SLOW = 3'b010,
    M_AUTO_FAST = 3'b011,
    M_RSV4      = 3'b100,
    M_RSV5      = 3'b101,
    M_RSV6      = 3'b110,
    M_SET_EOC   = 3'b111
  } seq_mode_e;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_ROWHOLD  = 3'd1,
    S_COLSETUP = 3'd2,
    S_CASACT   = 3'd3,
    S_REFRESH  = 3'd4,
    S_PRECHG   = 3'd5
  } seq_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic rasEn;
    logic rasAll;
    logic casEn;
    logic selCol;
    logic selRef;
  } seq_strobe_t;

  function automatic logic isAutoMode(input logic [2:0] m);
    return (m == M_AUTO_SLOW) || (m == M_AUTO_FAST);
  endfunction

  function automatic logic isExtMode(input logic [2:0] m);
    return (m == M_EXT_BANK) || (m == M_EXT_ALL);
  endfunction

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int ROW_HOLD_FAST = 2,
  parameter int ROW_HOLD_SLOW = 3,
  parameter int COL_SETUP     = 1,
  parameter int PRECHARGE     = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  mode,
  input  logic        accessN,
  input  logic        extCasN,
  input  logic        extColSel,
  input  logic        refreshGrant,
  output seq_strobe_t strobes
);

  localparam int MAX_A    = (ROW_HOLD_FAST > ROW_HOLD_SLOW) ? ROW_HOLD_FAST : ROW_HOLD_SLOW;
  localparam int MAX_B    = (COL_SETUP > PRECHARGE) ? COL_SETUP : PRECHARGE;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);

  localparam logic [CNT_W-1:0] FAST_LOAD  = CNT_W'(ROW_HOLD_FAST - 1);
  localparam logic [CNT_W-1:0] SLOW_LOAD  = CNT_W'(ROW_HOLD_SLOW - 1);
  localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(COL_SETUP - 1);
  localparam logic [CNT_W-1:0] PRE_LOAD   = CNT_W'(PRECHARGE - 1);

  seq_state_e       state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             accQ, casQ, colQ, refQ;
  logic [2:0]       modeQ;
  logic             startSeq;
  logic             autoBusy;

  // Sampled copies of the external controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= 1'b1;
      casQ  <= 1'b1;
      colQ  <= 1'b0;
      refQ  <= 1'b0;
      modeQ <= M_SET_EOC;
    end else begin
      accQ  <= accessN;
      casQ  <= extCasN;
      colQ  <= extColSel;
      refQ  <= refreshGrant;
      modeQ <= mode;
    end
  end

  assign startSeq = !accessN && accQ && isAutoMode(mode);
  assign autoBusy = (state == S_ROWHOLD) || (state == S_COLSETUP) || (state == S_CASACT);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      S_IDLE: begin
        if (startSeq) begin
          if (refreshGrant) begin
            nextState = S_REFRESH;
          end else begin
            nextState = S_ROWHOLD;
            nextCnt   = (mode == M_AUTO_FAST) ? FAST_LOAD : SLOW_LOAD;
          end
        end
      end
      S_ROWHOLD: begin
        if (accessN) begin
          nextState = S_PRECHG;
          nextCnt   = PRE_LOAD;
        end else if (cnt == '0) begin
          nextState = S_COLSETUP;
          nextCnt   = SETUP_LOAD;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      S_COLSETUP: begin
        if (accessN) begin
          nextState = S_PRECHG;
          nextCnt   = PRE_LOAD;
        end else if (cnt == '0) begin
          nextState = S_CASACT;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      S_CASACT, S_REFRESH: begin
        if (accessN) begin
          nextState = S_PRECHG;
          nextCnt   = PRE_LOAD;
        end
      end
      S_PRECHG: begin
        if (cnt == '0) nextState = S_IDLE;
        else           nextCnt   = cnt - 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  // Strobe encoding per state and mode
  always_comb begin
    strobes = '0;
    unique case (state)
      S_ROWHOLD:  strobes.rasEn = 1'b1;
      S_COLSETUP: begin
        strobes.rasEn  = 1'b1;
        strobes.selCol = 1'b1;
      end
      S_CASACT: begin
        strobes.rasEn  = 1'b1;
        strobes.selCol = 1'b1;
        strobes.casEn  = 1'b1;
      end
      S_REFRESH: begin
        strobes.rasEn  = 1'b1;
        strobes.rasAll = 1'b1;
        strobes.selRef = 1'b1;
      end
      S_PRECHG: strobes.selRef = refQ;
      default: begin
        strobes.selRef = refQ;
        if (isExtMode(modeQ)) begin
          strobes.rasEn  = !accQ;
          strobes.rasAll = (modeQ == M_EXT_ALL) || refQ;
          strobes.casEn  = !casQ && !refQ;
          strobes.selCol = colQ && !refQ;
        end
      end
    endcase
  end

  assert_row_hold_done_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COLSETUP && $past(state) == S_ROWHOLD) |-> ($past(cnt) == '0));

  assert_cas_after_setup_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CASACT && $past(state) != S_CASACT) |-> ($past(state) == S_COLSETUP));

  assert_release_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (autoBusy && accessN) |=> (state == S_PRECHG));

  assert_precharge_ignore_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PRECHG) |=> !((state == S_ROWHOLD) || (state == S_REFRESH)));

endmodule

// File: rtl/dram_seq_dpath.sv
module dram_seq_dpath
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BANKS  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       addrLoad,
  input  logic [ADDR_W-1:0]          rowIn,
  input  logic [ADDR_W-1:0]          colIn,
  input  logic [$clog2(BANKS)-1:0]   bankIn,
  input  logic [ADDR_W-1:0]          refreshAddr,
  input  seq_strobe_t                strobes,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [BANKS-1:0]           rasN,
  output logic                       casN
);

  localparam int BANK_W = $clog2(BANKS);

  logic [ADDR_W-1:0] rowQ, colQ;
  logic [BANK_W-1:0] bankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ  <= '0;
      colQ  <= '0;
      bankQ <= '0;
    end else if (addrLoad) begin
      rowQ  <= rowIn;
      colQ  <= colIn;
      bankQ <= bankIn;
    end
  end

  assign memAddr = strobes.selRef ? refreshAddr :
                   strobes.selCol ? colQ : rowQ;

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    assign rasN[b] = !(strobes.rasEn && (strobes.rasAll || (bankQ == BANK_W'(b))));
  end

  assign casN = !strobes.casEn;

  assert_single_bank_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rasEn && !strobes.rasAll) |-> ($countones(rasN) == BANKS - 1));

  assert_ref_no_cas_R10 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.selRef |-> casN);

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int BANKS         = 4,
  parameter int ROW_HOLD_FAST = 2,
  parameter int ROW_HOLD_SLOW = 3,
  parameter int COL_SETUP     = 1,
  parameter int PRECHARGE     = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2:0]               mode,
  input  logic                     addrLoad,
  input  logic [ADDR_W-1:0]        rowIn,
  input  logic [ADDR_W-1:0]        colIn,
  input  logic [$clog2(BANKS)-1:0] bankIn,
  input  logic                     accessN,
  input  logic                     extCasN,
  input  logic                     extColSel,
  input  logic                     refreshGrant,
  input  logic [ADDR_W-1:0]        refreshAddr,
  input  logic                     weInN,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [BANKS-1:0]         rasN,
  output logic                     casN,
  output logic                     weN
);

  seq_strobe_t strobes;

  dram_seq_ctrl #(
    .ROW_HOLD_FAST(ROW_HOLD_FAST),
    .ROW_HOLD_SLOW(ROW_HOLD_SLOW),
    .COL_SETUP    (COL_SETUP),
    .PRECHARGE    (PRECHARGE)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .mode        (mode),
    .accessN     (accessN),
    .extCasN     (extCasN),
    .extColSel   (extColSel),
    .refreshGrant(refreshGrant),
    .strobes     (strobes)
  );

  dram_seq_dpath #(
    .ADDR_W(ADDR_W),
    .BANKS (BANKS)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .addrLoad   (addrLoad),
    .rowIn      (rowIn),
    .colIn      (colIn),
    .bankIn     (bankIn),
    .refreshAddr(refreshAddr),
    .strobes    (strobes),
    .memAddr    (memAddr),
    .rasN       (rasN),
    .casN       (casN)
  );

  assign weN = weInN;

endmodule

// File: tb/dram_access_seq_test.sv
module dram_access_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] mode = 3'b011;
  logic       addrLoad = 1'b0;
  logic [8:0] rowIn = '0, colIn = '0, refreshAddr = '0;
  logic [1:0] bankIn = '0;
  logic       accessN = 1'b1, extCasN = 1'b1, extColSel = 1'b0;
  logic       refreshGrant = 1'b0, weInN = 1'b1;
  logic [8:0] memAddr;
  logic [3:0] rasN;
  logic       casN, weN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    logic [3:0] ras;
    logic       cas;
    logic [8:0] addr;
  } exp_t;
  exp_t q[$];

  dram_access_seq uut (
    .clk(clk), .rstN(rstN), .mode(mode), .addrLoad(addrLoad),
    .rowIn(rowIn), .colIn(colIn), .bankIn(bankIn), .accessN(accessN),
    .extCasN(extCasN), .extColSel(extColSel), .refreshGrant(refreshGrant),
    .refreshAddr(refreshAddr), .weInN(weInN), .memAddr(memAddr),
    .rasN(rasN), .casN(casN), .weN(weN)
  );

  always #2 clk = ~clk;

  // Monitor: compare one expected item just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rasN !== e.ras || casN !== e.cas || memAddr !== e.addr) begin
          fails++;
          $display("FAIL %s: rasN=%b casN=%b memAddr=%h expected rasN=%b casN=%b memAddr=%h",
                   e.tag, rasN, casN, memAddr, e.ras, e.cas, e.addr);
        end
      end
    end
  end

  // Driver: inputs were set at a falling edge; push expectation for the next rising edge
  task automatic cyc(input string tag, input logic [3:0] eRas, input logic eCas,
                     input logic [8:0] eAddr);
    exp_t e;
    e.tag = tag; e.ras = eRas; e.cas = eCas; e.addr = eAddr;
    q.push_back(e);
    #0;
    checks++;
    if (weN !== weInN) begin
      fails++;
      $display("FAIL R12: weN=%b expected %b", weN, weInN);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checks++;
    if (rasN !== 4'hF || casN !== 1'b1 || memAddr !== 9'h000) begin
      fails++;
      $display("FAIL R1: rasN=%b casN=%b memAddr=%h expected 1111 1 000", rasN, casN, memAddr);
    end

    // R2 load and hold
    addrLoad = 1; rowIn = 9'h155; colIn = 9'h0AA; bankIn = 2;
    cyc("R2 load", 4'hF, 1, 9'h155);
    addrLoad = 0; rowIn = 9'h1FF; colIn = 9'h001; bankIn = 0; weInN = 0;
    cyc("R2 hold", 4'hF, 1, 9'h155);

    // R3/R4 fast automatic access, bank 2
    accessN = 0; weInN = 1;
    cyc("R3 ras", 4'b1011, 1, 9'h155);
    cyc("R4 hold1", 4'b1011, 1, 9'h155);
    cyc("R4 col", 4'b1011, 1, 9'h0AA);
    cyc("R4 cas", 4'b1011, 0, 9'h0AA);
    cyc("R4 keep", 4'b1011, 0, 9'h0AA);
    // R6 release then R7 re-strobe in precharge
    accessN = 1;
    cyc("R6 release", 4'hF, 1, 9'h155);
    accessN = 0;
    cyc("R7 ignored", 4'hF, 1, 9'h155);
    cyc("R7 still idle", 4'hF, 1, 9'h155);
    accessN = 1;
    cyc("R7 idle", 4'hF, 1, 9'h155);

    // R5 slow automatic access, bank 0
    mode = 3'b010; addrLoad = 1; rowIn = 9'h0F0; colIn = 9'h10F; bankIn = 0;
    cyc("R2 load2", 4'hF, 1, 9'h0F0);
    addrLoad = 0; accessN = 0;
    cyc("R5 ras", 4'b1110, 1, 9'h0F0);
    cyc("R5 hold1", 4'b1110, 1, 9'h0F0);
    cyc("R5 hold2", 4'b1110, 1, 9'h0F0);
    cyc("R5 col", 4'b1110, 1, 9'h10F);
    cyc("R5 cas", 4'b1110, 0, 9'h10F);
    accessN = 1;
    cyc("R6 release2", 4'hF, 1, 9'h0F0);
    cyc("R6 idle", 4'hF, 1, 9'h0F0);

    // R6 abort during row hold (fast)
    mode = 3'b011; accessN = 0;
    cyc("R3 ras b0", 4'b1110, 1, 9'h0F0);
    accessN = 1;
    cyc("R6 abort", 4'hF, 1, 9'h0F0);
    cyc("R6 abort idle", 4'hF, 1, 9'h0F0);

    // R8 external single-bank mode, bank 1
    mode = 3'b000; addrLoad = 1; rowIn = 9'h033; colIn = 9'h1C4; bankIn = 1;
    cyc("R8 load", 4'hF, 1, 9'h033);
    addrLoad = 0; accessN = 0;
    cyc("R8 ras", 4'b1101, 1, 9'h033);
    extColSel = 1;
    cyc("R8 col", 4'b1101, 1, 9'h1C4);
    extCasN = 0;
    cyc("R8 cas", 4'b1101, 0, 9'h1C4);
    extCasN = 1; extColSel = 0;
    cyc("R8 back", 4'b1101, 1, 9'h033);
    accessN = 1;
    cyc("R8 off", 4'hF, 1, 9'h033);

    // R9 external all-bank mode
    mode = 3'b001; accessN = 0;
    cyc("R9 all", 4'b0000, 1, 9'h033);
    accessN = 1;
    cyc("R9 off", 4'hF, 1, 9'h033);

    // R10 refresh grant in automatic mode
    mode = 3'b011; refreshGrant = 1; refreshAddr = 9'h07E;
    cyc("R10 addr", 4'hF, 1, 9'h07E);
    accessN = 0;
    cyc("R10 all ras", 4'b0000, 1, 9'h07E);
    cyc("R10 no cas1", 4'b0000, 1, 9'h07E);
    cyc("R10 no cas2", 4'b0000, 1, 9'h07E);
    cyc("R10 no cas3", 4'b0000, 1, 9'h07E);
    accessN = 1;
    cyc("R10 end", 4'hF, 1, 9'h07E);
    refreshGrant = 0;
    cyc("R10 drop", 4'hF, 1, 9'h033);

    // R11 reserved and end-of-count modes
    mode = 3'b111;
    cyc("R11 eoc idle", 4'hF, 1, 9'h033);
    accessN = 0; extCasN = 0;
    cyc("R11 eoc strobe", 4'hF, 1, 9'h033);
    cyc("R11 eoc strobe2", 4'hF, 1, 9'h033);
    accessN = 1; extCasN = 1; mode = 3'b100;
    cyc("R11 rsv idle", 4'hF, 1, 9'h033);
    accessN = 0; extCasN = 0;
    cyc("R11 rsv strobe", 4'hF, 1, 9'h033);
    cyc("R11 rsv strobe2", 4'hF, 1, 9'h033);
    accessN = 1; extCasN = 1;
    cyc("R11 rsv end", 4'hF, 1, 9'h033);

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule